// File: doc/BRIEF.md
# Bus-master IDE DMA engine

This block is a single-channel bus-master DMA engine for an ATA disk port. Software programs a descriptor table pointer and a direction, then sets a go bit. The engine reads 8-byte descriptors from memory, one after another. Each descriptor names a physical base address and a byte count. For each descriptor the engine moves 16-bit halfwords between memory and the drive data port, one halfword for each drive request. When the descriptor flagged as the last one has been used up, the engine drops its active flag and raises an interrupt flag.

Memory is reached through a simple 32-bit request/grant port. A halfword sits in the upper or lower lane of the 32-bit word, as address bit 1 selects. The drive side is a level request with a one-cycle acknowledge strobe, and each strobe moves one halfword. Every descriptor is validated as soon as it is fetched. A region that would cross a 64 KiB address boundary, or that has an odd base or an odd count, stops the engine with the error flag set.

Top module: `dma_engine`

## Requirements
- R1: After reset the command register reads 0, the status register reads only the simplex bit (bit 7, from parameter SIMPLEX, default 0), and the table pointer reads 0.
- R2: The register window is at byte offsets 0 (command), 2 (status) and 4 (table pointer). Command bit 0 is go and bit 3 is direction, where 1 means drive to memory. Status bit 0 is active, bit 1 is error, bit 2 is interrupt, and bits 5 and 6 are drive-capable flags that software reads and writes. The pointer register always reads its low two bits as 0.
- R3: When go changes from 0 to 1 while the engine is idle, active is set and descriptors are fetched starting at the pointer. Word 0 of a descriptor is the base address. Word 1 holds the byte count in bits 15:0 and the last-descriptor flag in bit 31. The next descriptor is 8 bytes further on.
- R4: When the direction is memory to drive, halfwords are read from ascending addresses. Address bit 1 selects memory bits 31:16 (when 1) or 15:0 (when 0), and the halfword is presented on drv_wdata with drv_ack.
- R5: When the direction is drive to memory, each halfword on drv_rdata, taken with drv_ack, is written to ascending addresses with a two-byte write strobe in the lane that address bit 1 selects.
- R6: When the last descriptor finishes and the drive request is low, the interrupt bit is set, the active bit is cleared and the error bit stays clear.
- R7: When the last descriptor finishes while the drive still requests data, the error and interrupt bits are set and active is cleared.
- R8: A count field of 0 means 65536 bytes.
- R9: A descriptor whose region crosses a 64 KiB boundary, or whose base or count is odd, sets error, clears active, leaves interrupt clear and moves no data.
- R10: Clearing go during a transfer stops the engine after the halfword in flight. Active is cleared, interrupt is not set, and no further halfword moves.
- R11: While active, writes to the table pointer and to the direction bit are ignored.
- R12: Writing 1 to the error or interrupt bit clears it, and writing 0 leaves it unchanged.
- R13: drv_ack is given only while drv_req is high, with one halfword per strobe. mem_req, once raised, holds its address and direction until mem_gnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, follows reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory access completes this cycle |
| drv_req | input | 1 | Drive wants a halfword moved |
| drv_ack | output | 1 | One halfword moved this cycle |
| drv_rdata | input | 16 | Halfword from the drive |
| drv_wdata | output | 16 | Halfword to the drive |

## Verification
The hardest situation to reach is the end of the table while the drive still has data. A second hard case is an abort that falls in the middle of a memory handshake held off by random grant stalls. The bench's drive model is loaded with more halfwords than the table describes to force the first case. It triggers an abort once a chosen number of halfwords has moved in the drive-to-memory direction to force the second. Zero-count descriptors are placed on a 64 KiB-aligned base so that they pass validation, which shows that the engine keeps running well past any small count.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = 16;
    localparam int CNT_LG     = 16;
    localparam int CNT_W      = CNT_LG + 1;
    localparam int DESC_BYTES = 8;
    localparam int HALF_BYTES = HALF_W / 8;

    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_PTR  = 3'd4;

    localparam int B_GO    = 0;
    localparam int B_TOMEM = 3;
    localparam int B_ACT   = 0;
    localparam int B_ERR   = 1;
    localparam int B_IRQ   = 2;
    localparam int B_CAP0  = 5;
    localparam int B_CAP1  = 6;

    typedef enum logic [2:0] {
        E_IDLE, E_FET0, E_FET1, E_WAIT, E_MEM, E_DRV, E_END
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic                go;
        logic                tomem;
        logic                act;
        logic                err;
        logic                irq;
        logic [1:0]          cap;
        logic [ADDR_W-1:2]   tbl;
        logic [ADDR_W-1:0]   cur;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    left;
        logic                last;
        logic [HALF_W-1:0]   hw;
    } eng_t;
endpackage

// File: rtl/dma_prd_check.sv
`timescale 1ns/1ps
module dma_prd_check #(
    parameter int AW = 32,
    parameter int LG = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] word,
    output logic [LG:0]   bytes,
    output logic          last,
    output logic          bad
);
    logic [LG-1:0] cnt;
    logic [LG+1:0] reach;
    logic          unused_hi;

    assign cnt       = word[LG-1:0];
    assign last      = word[AW-1];
    assign bytes     = (cnt == '0) ? {1'b1, {LG{1'b0}}} : {1'b0, cnt};
    assign reach     = {2'b00, base[LG-1:0]} + {1'b0, bytes};
    assign bad       = base[0] | cnt[0] | (reach > {2'b01, {LG{1'b0}}});
    assign unused_hi = ^{word[AW-2:LG], base[AW-1:LG]};
endmodule

// File: rtl/dma_lane.sv
`timescale 1ns/1ps
module dma_lane #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic            sel_hi,
    input  logic [DW-1:0]   rword,
    input  logic [HW-1:0]   hw_in,
    output logic [HW-1:0]   hw_out,
    output logic [DW-1:0]   wword,
    output logic [DW/8-1:0] strb
);
    localparam int SB = DW / 16;

    assign hw_out = sel_hi ? rword[HW +: HW] : rword[0 +: HW];
    assign wword  = {hw_in, hw_in};
    assign strb   = sel_hi ? {{SB{1'b1}}, {SB{1'b0}}} : {{SB{1'b0}}, {SB{1'b1}}};
endmodule

// File: rtl/dma_engine.sv
`timescale 1ns/1ps
module dma_engine
    import dma_pkg::*;
#(
    parameter bit SIMPLEX = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W/8-1:0] mem_wstrb,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_gnt,
    input  logic               drv_req,
    output logic               drv_ack,
    input  logic [HALF_W-1:0]  drv_rdata,
    output logic [HALF_W-1:0]  drv_wdata
);
    eng_t q_q, q_d;
    logic kick, adv;
    logic [CNT_W-1:0]    desc_bytes;
    logic                desc_last, desc_bad;
    logic [HALF_W-1:0]   lane_hw;
    logic [DATA_W-1:0]   lane_wword;
    logic [DATA_W/8-1:0] lane_strb;

    // Signals brought out for the bound checker
    logic              act_w, go_w, irq_w, err_w;
    logic [ADDR_W-1:0] tbl_w;
    assign act_w = q_q.act;
    assign go_w  = q_q.go;
    assign irq_w = q_q.irq;
    assign err_w = q_q.err;
    assign tbl_w = {q_q.tbl, 2'b00};

    dma_prd_check #(.AW(ADDR_W), .LG(CNT_LG)) u_desc (
        .base(q_q.addr), .word(mem_rdata),
        .bytes(desc_bytes), .last(desc_last), .bad(desc_bad)
    );

    dma_lane #(.DW(DATA_W), .HW(HALF_W)) u_lane (
        .sel_hi(q_q.addr[1]), .rword(mem_rdata), .hw_in(q_q.hw),
        .hw_out(lane_hw), .wword(lane_wword), .strb(lane_strb)
    );

    always_comb begin
        q_d  = q_q;
        kick = 1'b0;
        adv  = 1'b0;

        // Register writes; engine updates below take precedence
        if (reg_we) begin
            case (reg_addr)
                OFS_CMD: begin
                    q_d.go = reg_wdata[B_GO];
                    if (!q_q.act) q_d.tomem = reg_wdata[B_TOMEM];
                    kick = reg_wdata[B_GO] & ~q_q.go & ~q_q.act;
                end
                OFS_STAT: begin
                    if (reg_wdata[B_ERR]) q_d.err = 1'b0;
                    if (reg_wdata[B_IRQ]) q_d.irq = 1'b0;
                    q_d.cap = reg_wdata[B_CAP1:B_CAP0];
                end
                OFS_PTR: if (!q_q.act) q_d.tbl = reg_wdata[ADDR_W-1:2];
                default: ;
            endcase
        end

        case (q_q.st)
            E_IDLE: if (kick) begin
                q_d.act = 1'b1;
                q_d.cur = {q_q.tbl, 2'b00};
                q_d.st  = E_FET0;
            end
            E_FET0: if (mem_gnt) begin
                q_d.addr = mem_rdata;
                q_d.st   = E_FET1;
            end
            E_FET1: if (mem_gnt) begin
                if (desc_bad) begin
                    q_d.err = 1'b1;
                    q_d.act = 1'b0;
                    q_d.st  = E_IDLE;
                end else begin
                    q_d.left = desc_bytes;
                    q_d.last = desc_last;
                    q_d.st   = E_WAIT;
                end
            end
            E_WAIT: begin
                if (!q_q.go) begin
                    q_d.act = 1'b0;
                    q_d.st  = E_IDLE;
                end else if (drv_req) begin
                    if (q_q.tomem) q_d.hw = drv_rdata;
                    q_d.st = E_MEM;
                end
            end
            E_MEM: if (mem_gnt) begin
                if (q_q.tomem) begin
                    adv = 1'b1;
                end else begin
                    q_d.hw = lane_hw;
                    q_d.st = E_DRV;
                end
            end
            E_DRV: adv = 1'b1;
            E_END: begin
                q_d.act = 1'b0;
                q_d.irq = 1'b1;
                if (drv_req) q_d.err = 1'b1;
                q_d.st  = E_IDLE;
            end
            default: q_d.st = E_IDLE;
        endcase

        if (adv) begin
            q_d.addr = q_q.addr + ADDR_W'(HALF_BYTES);
            q_d.left = q_q.left - CNT_W'(HALF_BYTES);
            if (q_q.left == CNT_W'(HALF_BYTES)) begin
                if (q_q.last) begin
                    q_d.st = E_END;
                end else if (q_q.go) begin
                    q_d.cur = q_q.cur + ADDR_W'(DESC_BYTES);
                    q_d.st  = E_FET0;
                end else begin
                    q_d.act = 1'b0;
                    q_d.st  = E_IDLE;
                end
            end else begin
                q_d.st = E_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign mem_req   = (q_q.st == E_FET0) || (q_q.st == E_FET1) || (q_q.st == E_MEM);
    assign mem_we    = (q_q.st == E_MEM) && q_q.tomem;
    assign mem_addr  = (q_q.st == E_FET0) ? q_q.cur :
                       (q_q.st == E_FET1) ? q_q.cur + ADDR_W'(4) : q_q.addr;
    assign mem_wdata = lane_wword;
    assign mem_wstrb = mem_we ? lane_strb : '0;
    assign drv_ack   = ((q_q.st == E_WAIT) && q_q.go && q_q.tomem && drv_req) ||
                       (q_q.st == E_DRV);
    assign drv_wdata = q_q.hw;

    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = {28'd0, q_q.tomem, 2'b00, q_q.go};
            OFS_STAT: reg_rdata = {24'd0, SIMPLEX, q_q.cap, 2'b00, q_q.irq, q_q.err, q_q.act};
            OFS_PTR:  reg_rdata = {q_q.tbl, 2'b00};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_engine_chk.sv
`timescale 1ns/1ps
module dma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        act,
    input logic        go,
    input logic        irq,
    input logic        err,
    input logic [31:0] tbl,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        drv_req,
    input logic        drv_ack
);
    // R13
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_ack |-> drv_req);

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> $stable(tbl));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (!mem_req && !drv_ack));

    // R6
    stop_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(act) && go) |-> (irq || err));

    // R9
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);
endmodule

bind dma_engine dma_engine_chk u_dma_engine_chk (
    .clk(clk), .rst_n(rst_n), .act(act_w), .go(go_w), .irq(irq_w), .err(err_w),
    .tbl(tbl_w), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .drv_req(drv_req), .drv_ack(drv_ack)
);

// File: tb/dma_engine_bench.sv
`timescale 1ns/1ps
module dma_engine_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_wstrb;
    logic        drv_req, drv_ack;
    logic [15:0] drv_rdata, drv_wdata;

    int n_chk = 0;
    int n_fail = 0;

    dma_engine u_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .drv_req(drv_req), .drv_ack(drv_ack), .drv_rdata(drv_rdata),
        .drv_wdata(drv_wdata)
    );

    // Memory model: 16 KiB, aliased on address bits 13:2
    logic [31:0] mem [0:4095];
    logic        bw_en;
    logic [11:0] bw_idx;
    logic [31:0] bw_data;
    always @(posedge clk) begin
        if (bw_en) mem[bw_idx] <= bw_data;
        else if (mem_req && mem_gnt && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) mem[mem_addr[13:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
    assign mem_rdata = mem[mem_addr[13:2]];
    always @(negedge clk) mem_gnt <= mem_req && ($urandom_range(3, 0) != 0);

    // Drive model
    logic [15:0] src [0:1023];
    logic [15:0] got [0:1023];
    int  drv_left = 0;
    int  didx = 0;
    logic load;
    int  load_n;
    always @(posedge clk) begin
        if (load) begin
            drv_left <= load_n;
            didx     <= 0;
        end else if (drv_ack) begin
            got[didx[9:0]] <= drv_wdata;
            didx <= didx + 1;
            if (drv_left > 0) drv_left <= drv_left - 1;
        end
    end
    assign drv_req   = (drv_left > 0);
    assign drv_rdata = src[didx[9:0]];

    function automatic logic [15:0] mem_hw(logic [31:0] a);
        return a[1] ? mem[a[13:2]][31:16] : mem[a[13:2]][15:0];
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_word(int idx, logic [31:0] v);
        @(negedge clk);
        bw_en = 1'b1; bw_idx = idx[11:0]; bw_data = v;
    endtask

    task automatic put_end();
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic set_desc(int slot, logic [31:0] base, logic [31:0] w1);
        put_word(32'h40 + 2 * slot, base);
        put_word(32'h41 + 2 * slot, w1);
    endtask

    task automatic drive_setup(int n);
        @(negedge clk);
        load = 1'b1; load_n = n;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int t = 0;
        do begin
            reg_read(3'd2, v);
            t++;
        end while (v[0] && t < 20000);
        if (t >= 20000) check(1'b0, "watchdog idle", v, 0);
    endtask

    task automatic wait_moved(int n);
        int t = 0;
        while (didx < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) check(1'b0, "watchdog moved", didx, n);
    endtask

    task automatic run_xfer(int nd, bit tomem);
        logic [31:0] b [4];
        int c [4];
        int total = 0;
        int k = 0;
        int mism = 0;
        logic [31:0] v;
        for (int i = 0; i < nd; i++) begin
            b[i] = 32'h2000 + i * 32'h400 + 2 * $urandom_range(127, 0);
            c[i] = 2 + 2 * $urandom_range(99, 0);
            set_desc(i, b[i], {(i == nd - 1), 15'd0, 16'(c[i])});
            total += c[i] / 2;
        end
        put_end();
        if (tomem) for (int j = 0; j < total; j++) src[j] = 16'($urandom);
        reg_write(3'd4, 32'h100);
        drive_setup(total);
        reg_write(3'd0, tomem ? 32'h9 : 32'h1);
        wait_idle();
        for (int i = 0; i < nd; i++) begin
            for (int o = 0; o < c[i]; o += 2) begin
                logic [15:0] a, e;
                if (tomem) begin a = mem_hw(b[i] + o); e = src[k]; end
                else       begin a = got[k]; e = mem_hw(b[i] + o); end
                if (a != e) mism++;
                k++;
            end
        end
        check(mism == 0, tomem ? "R5 R3 data" : "R4 R3 data", mism, 0);
        check(didx == total, "R13 one halfword per strobe", didx, total);
        reg_read(3'd2, v);
        check(v == 32'h4, "R6 clean finish", v, 32'h4);
        reg_write(3'd2, 32'h0);
        reg_read(3'd2, v);
        check(v == 32'h4, "R12 writing 0 keeps irq", v, 32'h4);
        reg_write(3'd2, 32'h4);
        reg_read(3'd2, v);
        check(v == 32'h0, "R12 W1C irq", v, 32'h0);
        reg_write(3'd0, 32'h0);
    endtask

    task automatic single_bad(logic [31:0] base, logic [31:0] w1, string req);
        logic [31:0] v;
        set_desc(0, base, w1);
        put_end();
        reg_write(3'd4, 32'h100);
        drive_setup(8);
        reg_write(3'd0, 32'h1);
        wait_idle();
        reg_read(3'd2, v);
        check(v == 32'h2, req, v, 32'h2);
        check(didx == 0, req, didx, 0);
        reg_write(3'd2, 32'h2);
        reg_write(3'd0, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int d0;
        void'($urandom(32'h1d3a));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        bw_en = 1'b0; bw_idx = '0; bw_data = '0; load = 1'b0; load_n = 0;
        for (int j = 0; j < 1024; j++) src[j] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd0, v); check(v == 0, "R1 cmd", v, 0);
        reg_read(3'd2, v); check(v == 0, "R1 status", v, 0);
        reg_read(3'd4, v); check(v == 0, "R1 ptr", v, 0);

        // R2 register map
        reg_write(3'd4, 32'h0000_0103);
        reg_read(3'd4, v); check(v == 32'h100, "R2 ptr low bits", v, 32'h100);
        reg_write(3'd2, 32'h60);
        reg_read(3'd2, v); check(v == 32'h60, "R2 cap bits", v, 32'h60);
        reg_write(3'd2, 32'h20);
        reg_read(3'd2, v); check(v == 32'h20, "R2 cap bit 5", v, 32'h20);
        reg_write(3'd2, 32'h0);
        reg_write(3'd0, 32'h8);
        reg_read(3'd0, v); check(v == 32'h8, "R2 direction bit", v, 32'h8);
        reg_write(3'd0, 32'h0);

        // Fill data region with random words
        for (int j = 32'h800; j < 32'hC00; j++) put_word(j, $urandom);
        put_end();

        // R3 R4 memory to drive, R5 drive to memory
        run_xfer(1, 1'b0);
        run_xfer(3, 1'b0);
        run_xfer(2, 1'b1);
        run_xfer(3, 1'b1);

        // R7 table ends while drive still requests
        set_desc(0, 32'h2000, 32'h8000_0008);
        put_end();
        reg_write(3'd4, 32'h100);
        drive_setup(6);
        reg_write(3'd0, 32'h1);
        wait_idle();
        reg_read(3'd2, v); check(v == 32'h6, "R7 error and irq", v, 32'h6);
        check(didx == 4, "R7 halfwords moved", didx, 4);
        reg_write(3'd2, 32'h6);
        reg_read(3'd2, v); check(v == 32'h0, "R12 W1C both", v, 32'h0);
        reg_write(3'd0, 32'h0);

        // R9 boundary and odd checks, R8 zero count crossing
        single_bad(32'h0000_FFF8, 32'h8000_0010, "R9 64K crossing");
        single_bad(32'h0000_2000, 32'h8000_0007, "R9 odd count");
        single_bad(32'h0000_2001, 32'h8000_0008, "R9 odd base");
        single_bad(32'h0000_2000, 32'h8000_0000, "R8 zero count is 64K");

        // R8 zero count on aligned base keeps running; R11 writes ignored; R10 abort
        set_desc(0, 32'h0001_0000, 32'h8000_0000);
        put_end();
        reg_write(3'd4, 32'h100);
        drive_setup(40);
        reg_write(3'd0, 32'h1);
        wait_moved(40);
        repeat (5) @(negedge clk);
        reg_read(3'd2, v); check(v == 32'h1, "R8 still active", v, 32'h1);
        reg_write(3'd4, 32'h500);
        reg_read(3'd4, v); check(v == 32'h100, "R11 ptr held", v, 32'h100);
        reg_write(3'd0, 32'h9);
        reg_read(3'd0, v); check(v == 32'h1, "R11 direction held", v, 32'h1);
        reg_write(3'd0, 32'h0);
        repeat (8) @(negedge clk);
        reg_read(3'd2, v); check(v == 32'h0, "R10 abort idle", v, 32'h0);

        // R10 abort during drive to memory
        set_desc(0, 32'h2000, 32'h8000_0190);
        put_end();
        reg_write(3'd4, 32'h100);
        drive_setup(150);
        reg_write(3'd0, 32'h9);
        wait_moved(10);
        reg_write(3'd0, 32'h8);
        repeat (10) @(negedge clk);
        reg_read(3'd2, v); check(v == 32'h0, "R10 abort no irq", v, 32'h0);
        d0 = didx;
        repeat (20) @(negedge clk);
        check(didx == d0, "R10 no more halfwords", didx, d0);
        check(d0 < 150, "R10 stopped early", d0, 150);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule